// File: doc/BRIEF.md
# Critical-Word-First Line Refill Tracker

This block runs the refill of a single cache line after a load miss. It fetches the line from a memory with a 64-bit pipelined Wishbone interface. The missing doubleword goes out on the bus first. The remaining doublewords of the line follow in ascending order and wrap at the end of the line. Each acknowledged beat is written straight into the data RAM row of the chosen victim way. The block keeps one valid bit per row of the line in flight. The missing load completes from a forwarding register as soon as its own beat returns. A lookup port tells the surrounding cache whether a later access to the same line can be served already.

A zeroing request runs through the same beat sequence. It differs in three ways: the bus cycles are writes of zero data, zeros go into the RAM, and the tag is written only when the line was not already resident. All addresses on the ports are doubleword addresses, laid out as tag, then set index, then row within the line. The row field sits in the least significant bits.

Top module: `line_refill_tracker`

## Requirements
- R1: After reset, cyc, stb, the RAM write strobe, the tag write strobe and the completion pulse are all low, and every row valid bit is 0.
- R2: A refill's first bus request carries the start doubleword address. Each later request uses the next row of the same line, wrapping from the last row to row 0. stb stays high with an unchanged address while stall is high.
- R3: Exactly one request per row of the line is issued. The final request is for the row just before the start row, modulo the number of rows, and stb is low from the cycle after that request is accepted.
- R4: Accepting a refill clears all row valid bits. A row's bit reads 1 from the cycle after the acknowledge of its beat. Acknowledges return in request order.
- R5: In every cycle in which an acknowledge arrives during a refill, the RAM write strobe is high. The RAM write targets the victim way, at the set index concatenated with the row of that beat, and carries the returned data.
- R6: The completion pulse is high for one cycle, in the cycle after the first acknowledge. It carries that beat's data.
- R7: The hit output is high only while a refill is active and the looked-up address has the refilling line's index and tag. For a load, the looked-up row's valid bit must also be 1. For a store, the row does not matter.
- R8: For a zeroing request, wb_we_o is 1 and wb_dat_o is 0 on every request, and the RAM data and completion data are 0.
- R9: The tag write strobe is high in the first cycle after a refill is accepted, with the victim way, the index and the tag of the line. For a zeroing request whose start_present_i is 1, the strobe stays low.
- R10: cyc goes low in the cycle after the acknowledge of the final row. A start request that arrives while cyc is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a refill (accepted only when idle) |
| start_dw_i | input | ADDR_W-3 | Doubleword address of the missing access |
| start_way_i | input | log2(NUM_WAYS) | Victim way to fill |
| start_zero_i | input | 1 | Request is a line-zeroing operation |
| start_present_i | input | 1 | Line already resident (zeroing only: skip tag write) |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Bus request strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_adr_o | output | ADDR_W-3 | Bus doubleword address |
| wb_dat_o | output | 64 | Bus write data |
| wb_sel_o | output | 8 | Byte selects (all set) |
| wb_ack_i | input | 1 | Bus acknowledge |
| wb_stall_i | input | 1 | Bus not accepting a request |
| wb_dat_i | input | 64 | Bus read data |
| ram_we_o | output | 1 | Data RAM write strobe |
| ram_way_o | output | log2(NUM_WAYS) | Data RAM way |
| ram_row_o | output | log2(NUM_SETS)+log2(LINE_ROWS) | Data RAM row (index, row in line) |
| ram_wdata_o | output | 64 | Data RAM write data |
| tag_we_o | output | 1 | Tag RAM write strobe |
| tag_way_o | output | log2(NUM_WAYS) | Tag RAM way |
| tag_index_o | output | log2(NUM_SETS) | Tag RAM set index |
| tag_value_o | output | ADDR_W-3-log2(NUM_SETS)-log2(LINE_ROWS) | Tag to store |
| row_valid_o | output | LINE_ROWS | Valid bit per row of the refilling line |
| probe_dw_i | input | ADDR_W-3 | Doubleword address of a later access |
| probe_store_i | input | 1 | Later access is a store |
| probe_hit_o | output | 1 | Later access may complete against the refilling line |
| done_o | output | 1 | Missing access completes this cycle |
| done_data_o | output | 64 | Forwarded data of the missing doubleword |

## Verification
The hardest situation to reach is a lookup of a row in the brief window between its acknowledge and the refill's end, while earlier rows are valid and later ones are not. A lookup on the wrong side of that boundary must give the opposite answer. The bench reaches it by sweeping the looked-up row on every cycle during refills that start at different rows. It also throttles the bus with pseudo-random stall and acknowledge gaps, so that requests run ahead of acknowledges by varying amounts. Wrap-around is pushed to its extremes with start rows 0 and 7, and one run throws a second start request into the middle of a refill.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

    localparam int WORD_BITS  = 64;
    localparam int SEL_W      = WORD_BITS / 8;
    localparam int BYTE_OFF_W = $clog2(SEL_W);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fill_state_e;

    function automatic logic [WORD_BITS-1:0] beat_data(input logic zeroing,
                                                       input logic [WORD_BITS-1:0] bus_word);
        return zeroing ? '0 : bus_word;
    endfunction

endpackage

// File: rtl/lrt_issue.sv
module lrt_issue #(
    parameter int ROW_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ROW_W-1:0] start_row,
    input  logic             stall,
    output logic             stb,
    output logic [ROW_W-1:0] req_row
);

    logic [ROW_W-1:0] final_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb       <= 1'b0;
            req_row   <= '0;
            final_row <= '0;
        end else if (load) begin
            stb       <= 1'b1;
            req_row   <= start_row;
            final_row <= ROW_W'(start_row - 1'b1);
        end else if (stb && !stall) begin
            if (req_row == final_row) begin
                stb <= 1'b0;
            end else begin
                req_row <= ROW_W'(req_row + 1'b1);
            end
        end
    end

    a_r2_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
        (stb && stall && !load) |=> (stb && $stable(req_row)));

    a_r3_drop_only_when_taken: assert property (@(posedge clk) disable iff (rst)
        $fell(stb) |-> $past(!stall));

endmodule

// File: rtl/lrt_rows.sv
module lrt_rows #(
    parameter int LINE_ROWS = 8,
    localparam int ROW_W = $clog2(LINE_ROWS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [ROW_W-1:0]     start_row,
    input  logic                 ack,
    output logic [ROW_W-1:0]     ack_row,
    output logic [LINE_ROWS-1:0] valid,
    output logic                 first_ack,
    output logic                 last_ack
);

    logic [ROW_W-1:0] first_row;
    logic [ROW_W-1:0] end_row;

    assign end_row   = ROW_W'(first_row - 1'b1);
    assign first_ack = ack && (ack_row == first_row);
    assign last_ack  = ack && (ack_row == end_row);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_row   <= '0;
            first_row <= '0;
        end else if (load) begin
            ack_row   <= start_row;
            first_row <= start_row;
        end else if (ack) begin
            ack_row <= ROW_W'(ack_row + 1'b1);
        end
    end

    for (genvar g = 0; g < LINE_ROWS; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst || load) begin
                valid[g] <= 1'b0;
            end else if (ack && (ack_row == ROW_W'(g))) begin
                valid[g] <= 1'b1;
            end
        end
    end

    a_r4_bits_only_rise: assert property (@(posedge clk) disable iff (rst)
        !load |=> ((valid | $past(valid)) == valid));

    a_r4_clear_on_start: assert property (@(posedge clk) disable iff (rst)
        load |=> (valid == '0));

endmodule

// File: rtl/lrt_match.sv
module lrt_match #(
    parameter int DW_W      = 29,
    parameter int LINE_ROWS = 8,
    parameter int IDX_W     = 4,
    localparam int ROW_W = $clog2(LINE_ROWS),
    localparam int TAG_W = DW_W - IDX_W - ROW_W
) (
    input  logic                 active,
    input  logic [TAG_W-1:0]     line_tag,
    input  logic [IDX_W-1:0]     line_idx,
    input  logic [LINE_ROWS-1:0] valid,
    input  logic [DW_W-1:0]      probe_dw,
    input  logic                 probe_store,
    output logic                 hit
);

    logic [ROW_W-1:0] p_row;
    logic [IDX_W-1:0] p_idx;
    logic [TAG_W-1:0] p_tag;
    logic             same_line;

    always_comb begin
        p_row     = probe_dw[ROW_W-1:0];
        p_idx     = probe_dw[ROW_W +: IDX_W];
        p_tag     = probe_dw[DW_W-1 -: TAG_W];
        same_line = active && (p_idx == line_idx) && (p_tag == line_tag);
        hit       = same_line && (probe_store || valid[p_row]);
    end

endmodule

// File: rtl/line_refill_tracker.sv
module line_refill_tracker
    import lrt_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LINE_ROWS = 8,
    parameter int NUM_SETS  = 16,
    parameter int NUM_WAYS  = 4,
    localparam int DW_W  = ADDR_W - BYTE_OFF_W,
    localparam int ROW_W = $clog2(LINE_ROWS),
    localparam int IDX_W = $clog2(NUM_SETS),
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int TAG_W = DW_W - IDX_W - ROW_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [DW_W-1:0]        start_dw_i,
    input  logic [WAY_W-1:0]       start_way_i,
    input  logic                   start_zero_i,
    input  logic                   start_present_i,
    output logic                   wb_cyc_o,
    output logic                   wb_stb_o,
    output logic                   wb_we_o,
    output logic [DW_W-1:0]        wb_adr_o,
    output logic [WORD_BITS-1:0]   wb_dat_o,
    output logic [SEL_W-1:0]       wb_sel_o,
    input  logic                   wb_ack_i,
    input  logic                   wb_stall_i,
    input  logic [WORD_BITS-1:0]   wb_dat_i,
    output logic                   ram_we_o,
    output logic [WAY_W-1:0]       ram_way_o,
    output logic [IDX_W+ROW_W-1:0] ram_row_o,
    output logic [WORD_BITS-1:0]   ram_wdata_o,
    output logic                   tag_we_o,
    output logic [WAY_W-1:0]       tag_way_o,
    output logic [IDX_W-1:0]       tag_index_o,
    output logic [TAG_W-1:0]       tag_value_o,
    output logic [LINE_ROWS-1:0]   row_valid_o,
    input  logic [DW_W-1:0]        probe_dw_i,
    input  logic                   probe_store_i,
    output logic                   probe_hit_o,
    output logic                   done_o,
    output logic [WORD_BITS-1:0]   done_data_o
);

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [WAY_W-1:0] way;
        logic             zero;
    } line_t;

    fill_state_e          state;
    line_t                line_q;
    logic                 accept;
    logic                 ack_eff;
    logic [ROW_W-1:0]     req_row;
    logic [ROW_W-1:0]     ack_row;
    logic                 first_ack;
    logic                 last_ack;
    logic                 tag_we_q;
    logic                 done_q;
    logic [WORD_BITS-1:0] done_data_q;

    assign accept  = start_i && (state == ST_IDLE);
    assign ack_eff = wb_ack_i && (state == ST_FILL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            line_q      <= '0;
            tag_we_q    <= 1'b0;
            done_q      <= 1'b0;
            done_data_q <= '0;
        end else begin
            tag_we_q <= accept && !(start_zero_i && start_present_i);
            done_q   <= first_ack && ack_eff;
            if (first_ack && ack_eff) begin
                done_data_q <= beat_data(line_q.zero, wb_dat_i);
            end
            if (accept) begin
                state       <= ST_FILL;
                line_q.tag  <= start_dw_i[DW_W-1 -: TAG_W];
                line_q.idx  <= start_dw_i[ROW_W +: IDX_W];
                line_q.way  <= start_way_i;
                line_q.zero <= start_zero_i;
            end else if (last_ack) begin
                state <= ST_IDLE;
            end
        end
    end

    lrt_issue #(
        .ROW_W(ROW_W)
    ) u_issue (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .start_row(start_dw_i[ROW_W-1:0]),
        .stall    (wb_stall_i),
        .stb      (wb_stb_o),
        .req_row  (req_row)
    );

    lrt_rows #(
        .LINE_ROWS(LINE_ROWS)
    ) u_rows (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .start_row(start_dw_i[ROW_W-1:0]),
        .ack      (ack_eff),
        .ack_row  (ack_row),
        .valid    (row_valid_o),
        .first_ack(first_ack),
        .last_ack (last_ack)
    );

    lrt_match #(
        .DW_W     (DW_W),
        .LINE_ROWS(LINE_ROWS),
        .IDX_W    (IDX_W)
    ) u_match (
        .active     (state == ST_FILL),
        .line_tag   (line_q.tag),
        .line_idx   (line_q.idx),
        .valid      (row_valid_o),
        .probe_dw   (probe_dw_i),
        .probe_store(probe_store_i),
        .hit        (probe_hit_o)
    );

    assign wb_cyc_o    = (state == ST_FILL);
    assign wb_we_o     = line_q.zero;
    assign wb_adr_o    = {line_q.tag, line_q.idx, req_row};
    assign wb_dat_o    = '0;
    assign wb_sel_o    = '1;

    assign ram_we_o    = ack_eff;
    assign ram_way_o   = line_q.way;
    assign ram_row_o   = {line_q.idx, ack_row};
    assign ram_wdata_o = beat_data(line_q.zero, wb_dat_i);

    assign tag_we_o    = tag_we_q;
    assign tag_way_o   = line_q.way;
    assign tag_index_o = line_q.idx;
    assign tag_value_o = line_q.tag;

    assign done_o      = done_q;
    assign done_data_o = done_data_q;

    a_r2_stb_inside_cyc: assert property (@(posedge clk) disable iff (rst)
        wb_stb_o |-> wb_cyc_o);

    a_r10_cyc_ends_on_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(wb_cyc_o) |-> $past(wb_ack_i));

    a_r6_done_follows_ack: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(wb_ack_i && wb_cyc_o));

    a_r9_tag_after_start: assert property (@(posedge clk) disable iff (rst)
        tag_we_o |-> ($past(start_i) && wb_cyc_o));

    a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (start_i && wb_cyc_o) |=> !tag_we_o);

endmodule

// File: tb/test_line_refill_tracker.sv
module test_line_refill_tracker;

    localparam int ADDR_W    = 32;
    localparam int LINE_ROWS = 8;
    localparam int NUM_SETS  = 16;
    localparam int NUM_WAYS  = 4;
    localparam int DW_W  = ADDR_W - 3;
    localparam int ROW_W = $clog2(LINE_ROWS);
    localparam int IDX_W = $clog2(NUM_SETS);
    localparam int WAY_W = $clog2(NUM_WAYS);
    localparam int TAG_W = DW_W - IDX_W - ROW_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [DW_W-1:0] start_dw_i = '0;
    logic [WAY_W-1:0] start_way_i = '0;
    logic start_zero_i = 1'b0;
    logic start_present_i = 1'b0;
    logic wb_cyc_o, wb_stb_o, wb_we_o;
    logic [DW_W-1:0] wb_adr_o;
    logic [63:0] wb_dat_o;
    logic [7:0] wb_sel_o;
    logic wb_ack_i = 1'b0;
    logic wb_stall_i = 1'b0;
    logic [63:0] wb_dat_i = '0;
    logic ram_we_o;
    logic [WAY_W-1:0] ram_way_o;
    logic [IDX_W+ROW_W-1:0] ram_row_o;
    logic [63:0] ram_wdata_o;
    logic tag_we_o;
    logic [WAY_W-1:0] tag_way_o;
    logic [IDX_W-1:0] tag_index_o;
    logic [TAG_W-1:0] tag_value_o;
    logic [LINE_ROWS-1:0] row_valid_o;
    logic [DW_W-1:0] probe_dw_i = '0;
    logic probe_store_i = 1'b0;
    logic probe_hit_o;
    logic done_o;
    logic [63:0] done_data_o;

    always #10 clk = ~clk;

    line_refill_tracker #(
        .ADDR_W(ADDR_W), .LINE_ROWS(LINE_ROWS), .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)
    ) i_line_refill_tracker (
        .clk(clk), .rst(rst),
        .start_i(start_i), .start_dw_i(start_dw_i), .start_way_i(start_way_i),
        .start_zero_i(start_zero_i), .start_present_i(start_present_i),
        .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o), .wb_adr_o(wb_adr_o),
        .wb_dat_o(wb_dat_o), .wb_sel_o(wb_sel_o), .wb_ack_i(wb_ack_i), .wb_stall_i(wb_stall_i),
        .wb_dat_i(wb_dat_i),
        .ram_we_o(ram_we_o), .ram_way_o(ram_way_o), .ram_row_o(ram_row_o), .ram_wdata_o(ram_wdata_o),
        .tag_we_o(tag_we_o), .tag_way_o(tag_way_o), .tag_index_o(tag_index_o), .tag_value_o(tag_value_o),
        .row_valid_o(row_valid_o),
        .probe_dw_i(probe_dw_i), .probe_store_i(probe_store_i), .probe_hit_o(probe_hit_o),
        .done_o(done_o), .done_data_o(done_data_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int unsigned rng = 32'h1234_5678;
    int stall_pct = 0;
    int ack_pct = 100;
    int k = 0;

    // stimulus request for the next cycle
    bit st_req = 0;
    logic [DW_W-1:0] st_dw = '0;
    logic [WAY_W-1:0] st_way = '0;
    bit st_zero = 0, st_present = 0;

    // reference model
    bit m_busy = 0;
    int m_issued = 0, m_acked = 0, m_srow = 0;
    logic [DW_W-1:0] m_base = '0;
    logic [WAY_W-1:0] m_way = '0;
    bit m_zero = 0, m_done = 0, m_tagwe = 0;
    logic [63:0] m_dd = '0;
    logic [LINE_ROWS-1:0] m_mask = '0;

    function automatic logic [63:0] mem_word(input logic [DW_W-1:0] a);
        return {32'(a) ^ 32'hC3A5_5A3C, 32'(~a)};
    endfunction

    function automatic logic [DW_W-1:0] row_dw(input int r);
        return {m_base[DW_W-1:ROW_W], ROW_W'(r % LINE_ROWS)};
    endfunction

    function automatic bit roll(input int pct);
        rng = rng * 32'd1103515245 + 32'd12345;
        return ((rng >> 16) % 100) < pct;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input bit do_check);
        bit exp_stb, exp_we, exp_hit, n_done, n_tagwe;
        logic [63:0] n_dd;
        int prow;
        logic [DW_W-1:0] pline;
        @(posedge clk);
        #2;
        k++;
        // drive phase
        start_i         = st_req;
        start_dw_i      = st_dw;
        start_way_i     = st_way;
        start_zero_i    = st_zero;
        start_present_i = st_present;
        wb_stall_i      = roll(stall_pct);
        wb_ack_i        = m_busy && (m_issued > m_acked) && roll(ack_pct);
        wb_dat_i        = wb_ack_i ? mem_word(row_dw(m_srow + m_acked)) : 64'hDEAD_BEEF_0BAD_F00D;
        prow  = k % LINE_ROWS;
        pline = m_base;
        if (k % 7 == 3) pline = m_base ^ (DW_W'(1) << ROW_W);
        if (k % 11 == 5) pline = m_base ^ (DW_W'(1) << (ROW_W + IDX_W));
        probe_dw_i    = {pline[DW_W-1:ROW_W], ROW_W'(prow)};
        probe_store_i = (k % 5 == 0);
        @(negedge clk);
        exp_stb = m_busy && (m_issued < LINE_ROWS);
        exp_we  = m_busy && wb_ack_i;
        if (do_check) begin
            chk("R10", "cyc", 64'(wb_cyc_o), 64'(m_busy));
            chk("R3", "stb", 64'(wb_stb_o), 64'(exp_stb));
            if (exp_stb) begin
                chk("R2", "request address", 64'(wb_adr_o), 64'(row_dw(m_srow + m_issued)));
                chk("R8", "bus write enable", 64'(wb_we_o), 64'(m_zero));
                if (m_zero) chk("R8", "bus write data", wb_dat_o, 64'd0);
            end
            chk("R5", "ram_we", 64'(ram_we_o), 64'(exp_we));
            if (exp_we) begin
                chk("R5", "ram row", 64'(ram_row_o),
                    64'({m_base[ROW_W +: IDX_W], ROW_W'((m_srow + m_acked) % LINE_ROWS)}));
                chk("R5", "ram way", 64'(ram_way_o), 64'(m_way));
                chk(m_zero ? "R8" : "R5", "ram data", ram_wdata_o,
                    m_zero ? 64'd0 : mem_word(row_dw(m_srow + m_acked)));
            end
            chk("R4", "row valid", 64'(row_valid_o), 64'(m_mask));
            chk("R6", "done", 64'(done_o), 64'(m_done));
            if (m_done) chk("R6", "done data", done_data_o, m_dd);
            chk("R9", "tag_we", 64'(tag_we_o), 64'(m_tagwe));
            if (m_tagwe) begin
                chk("R9", "tag way", 64'(tag_way_o), 64'(m_way));
                chk("R9", "tag index", 64'(tag_index_o), 64'(m_base[ROW_W +: IDX_W]));
                chk("R9", "tag value", 64'(tag_value_o), 64'(m_base[DW_W-1 -: TAG_W]));
            end
            exp_hit = m_busy && (pline[DW_W-1:ROW_W] == m_base[DW_W-1:ROW_W]) &&
                      (probe_store_i || m_mask[prow]);
            chk("R7", "probe hit", 64'(probe_hit_o), 64'(exp_hit));
        end
        // model update, mirroring the coming clock edge
        n_done  = m_busy && wb_ack_i && (m_acked == 0);
        n_dd    = m_zero ? 64'd0 : mem_word(row_dw(m_srow));
        n_tagwe = st_req && !m_busy && !(st_zero && st_present);
        if (rst) begin
            m_busy = 0; m_mask = '0; n_done = 0; n_tagwe = 0;
        end else if (m_busy) begin
            if (exp_stb && !wb_stall_i) m_issued++;
            if (wb_ack_i) begin
                m_mask[(m_srow + m_acked) % LINE_ROWS] = 1'b1;
                m_acked++;
                if (m_acked == LINE_ROWS) m_busy = 0;
            end
        end else if (st_req) begin
            m_busy   = 1;
            m_base   = {st_dw[DW_W-1:ROW_W], ROW_W'(0)};
            m_srow   = int'(st_dw[ROW_W-1:0]);
            m_way    = st_way;
            m_zero   = st_zero;
            m_issued = 0;
            m_acked  = 0;
            m_mask   = '0;
        end
        m_done  = n_done;
        if (n_done) m_dd = n_dd;
        m_tagwe = n_tagwe;
    endtask

    task automatic run_fill(input logic [DW_W-1:0] dw, input logic [WAY_W-1:0] way,
                            input bit zero, input bit present, input int s_pct, input int a_pct,
                            input bit intrude);
        int guard;
        stall_pct  = s_pct;
        ack_pct    = a_pct;
        st_dw      = dw;
        st_way     = way;
        st_zero    = zero;
        st_present = present;
        st_req     = 1;
        step(1);
        st_req = 0;
        guard = 0;
        while (m_busy && guard < 2000) begin
            // R10: a second start while busy must leave the refill untouched
            if (intrude && guard == 3) begin
                st_dw = dw ^ DW_W'(32'h155); st_way = way + 1'b1; st_req = 1;
            end else begin
                st_req = 0;
            end
            step(1);
            guard++;
        end
        st_req = 0;
        st_dw  = dw;
        if (guard >= 2000) begin
            n_chk++; n_bad++;
            $display("FAIL R10 refill never finished: actual busy expected idle");
        end
    endtask

    initial begin
        #(20 * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) step(0);
        rst = 1'b0;
        step(1);
        // R1: reset state
        chk("R1", "cyc after reset", 64'(wb_cyc_o), 64'd0);
        chk("R1", "stb after reset", 64'(wb_stb_o), 64'd0);
        chk("R1", "ram_we after reset", 64'(ram_we_o), 64'd0);
        chk("R1", "tag_we after reset", 64'(tag_we_o), 64'd0);
        chk("R1", "done after reset", 64'(done_o), 64'd0);
        chk("R1", "row valid after reset", 64'(row_valid_o), 64'd0);
        repeat (2) step(1);
        // load miss, full speed bus, start mid-line
        run_fill(DW_W'(32'h0ABC_1235), 2'd2, 0, 0, 0, 100, 0);
        repeat (2) step(1);
        // start at row 0, throttled bus
        run_fill(DW_W'(32'h0123_4560), 2'd1, 0, 0, 30, 60, 0);
        // start at last row, heavy throttling, intruding start (R10)
        run_fill(DW_W'(32'h0F0F_0AF7), 2'd3, 0, 0, 50, 40, 1);
        repeat (3) step(1);
        // zeroing, line absent: tag written
        run_fill(DW_W'(32'h0055_AA92), 2'd0, 1, 0, 20, 70, 0);
        // zeroing, line present: no tag write (R9, R8)
        run_fill(DW_W'(32'h0055_AA96), 2'd1, 1, 1, 10, 80, 0);
        // back-to-back load refill right after the previous one
        run_fill(DW_W'(32'h0ABC_1233), 2'd3, 0, 0, 40, 50, 0);
        repeat (4) step(1);
        chk("R4", "valid bits stay full after refill", 64'(row_valid_o), 64'({LINE_ROWS{1'b1}}));
        chk("R10", "idle after refills", 64'(wb_cyc_o), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule